// File: doc/BRIEF.md
# Masked Interrupt Vector Controller

This block gathers sixteen level-sensitive interrupt requests from local peripherals into one interrupt line toward the processor. Each request is held in a status bit that simply tracks its input level: it is set while the line is high and cleared once the line drops, with no latching. A software-writable enable mask selects which requests may reach the combined output. Whenever any request that is both present and enabled exists, the output is asserted.

A small 16-bit register port serves software. The source register, read-only at byte offset 0x00, reports the lowest-numbered line that is both present and enabled. It encodes it as (index + 1) shifted left by two, so a value of zero means nothing is pending. The enable mask sits at byte offset 0x02, can be read and written, and accepts halfword or single-byte writes. A byte write merges into the current mask. The output and the source register see a change on the request inputs, or a mask write, one clock later. All pins are plain control and status signals, with no handshake.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask reads 0x0010, the source register reads 0 and irq_out is low.
- R2: Each status bit follows the level of its request input; one clock edge after a line goes low it no longer counts as pending.
- R3: irq_out is high in the cycle after the clock edge at which (requests AND mask) is nonzero, and low in the cycle after it becomes zero.
- R4: A read at byte offset 0x00 returns ((i + 1) << 2), with i the lowest bit index set in (status AND mask); it returns 0 when no such bit exists, so bits [1:0] are always 0.
- R5: A request whose mask bit is 0 affects neither irq_out nor the source register.
- R6: With bus_byte = 0, a write to byte offset 0x02 or 0x03 loads all 16 bits of bus_wdata into the mask; a read at offset 0x02 or 0x03 returns the full mask.
- R7: With bus_byte = 1, a write at offset 0x02 replaces mask bits [7:0] with bus_wdata[7:0], and a write at offset 0x03 replaces mask bits [15:8] with bus_wdata[7:0]; the other byte of the mask keeps its value.
- R8: A mask write and a change on the request inputs in the same cycle both take effect on irq_out and the source register at the same following edge.
- R9: A write to any offset other than 0x02 or 0x03 leaves the mask unchanged.
- R10: A read at any offset from 0x04 upward returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 16 | Level-sensitive request lines, bit i is line i |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_byte | input | 1 | 1: byte write using bus_wdata[7:0]; 0: halfword write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational from registered state |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
Two functions of this block can meet in one cycle: a software write to the enable mask and a change on the request lines. The bench drives both in the same cycle, in both directions. In one case the line rises while its mask bit is being set; in the other a line rises while the mask is being cleared. At the next edge the bench requires irq_out and the source vector to match the new requests under the new mask, with no extra cycle and no stale value from the old mask. Around this, the bench sweeps every single line, every lowest-set position under a full mask, every single-bit mask, and a long run of pseudo-random request and mask pairs. In each case it computes the expected vector arithmetically.

// File: rtl/mivc_pkg.sv
package mivc_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned VEC_SHIFT = 2;

  typedef enum logic [1:0] {
    SLOT_VECTOR = 2'd0,
    SLOT_ENABLE = 2'd1,
    SLOT_EMPTY  = 2'd2
  } slot_e;
endpackage

// File: rtl/mivc_level_track.sv
module mivc_level_track #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] level_q
);
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q[g] <= 1'b0;
      else        level_q[g] <= req[g];
    end
  end
endmodule

// File: rtl/mivc_enable_reg.sv
module mivc_enable_reg
  import mivc_pkg::*;
#(
  parameter int unsigned W       = REG_W,
  parameter logic [W-1:0] RST_VAL = 16'h0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_byte,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_d,
  output logic [W-1:0] en_q
);
  localparam int unsigned HI_W = W - BYTE_W;

  always_comb begin
    en_d = en_q;
    if (wr_en) begin
      if (!wr_byte)   en_d = wdata;
      else if (wr_hi) en_d[W-1:BYTE_W] = wdata[HI_W-1:0];
      else            en_d[BYTE_W-1:0] = wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= RST_VAL;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/mivc_lowest_enc.sv
module mivc_lowest_enc
  import mivc_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned VW = REG_W
) (
  input  logic [N-1:0]  pend,
  output logic [VW-1:0] vector
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic          hit;
  logic [IW-1:0] idx;
  logic [VW-1:0] idx_ext;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend[k]) begin
        hit = 1'b1;
        idx = IW'(k);
      end
    end
    idx_ext = VW'(idx);
    vector  = hit ? ((idx_ext + VW'(1)) << VEC_SHIFT) : '0;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import mivc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter logic [15:0] MASK_RST  = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_byte,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 irq_out
);
  localparam int unsigned SLOT_W = ADDR_W - 1;

  logic [NUM_LINES-1:0] status_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mask_d;
  logic [NUM_LINES-1:0] pend;
  logic [REG_W-1:0]     vector;
  logic [SLOT_W-1:0]    slot_idx;
  slot_e                slot;
  logic                 mask_wr;
  logic                 irq_q;

  assign slot_idx = bus_addr[ADDR_W-1:1];

  always_comb begin
    if (slot_idx == SLOT_W'(0))      slot = SLOT_VECTOR;
    else if (slot_idx == SLOT_W'(1)) slot = SLOT_ENABLE;
    else                             slot = SLOT_EMPTY;
  end

  assign mask_wr = bus_wr && (slot == SLOT_ENABLE);

  mivc_level_track #(.N(NUM_LINES)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (irq_req),
    .level_q (status_q)
  );

  mivc_enable_reg #(.W(NUM_LINES), .RST_VAL(MASK_RST)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_wr),
    .wr_byte (bus_byte),
    .wr_hi   (bus_addr[0]),
    .wdata   (bus_wdata),
    .en_d    (mask_d),
    .en_q    (mask_q)
  );

  assign pend = status_q & mask_q;

  mivc_lowest_enc #(.N(NUM_LINES), .VW(REG_W)) u_enc (
    .pend   (pend),
    .vector (vector)
  );

  // Output flop sees next-state mask so a write acts at the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(irq_req & mask_d);
  end

  assign irq_out = irq_q;

  always_comb begin
    case (slot)
      SLOT_VECTOR: bus_rdata = vector;
      SLOT_ENABLE: bus_rdata = REG_W'(mask_q);
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_byte,
  input logic [15:0]   bus_wdata,
  input logic [15:0]   bus_rdata,
  input logic          irq_out,
  input logic [N-1:0]  status_q,
  input logic [N-1:0]  mask_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && mask_q == N'(16'h0010) && status_q == '0));

  // R3
  out_matches_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|(status_q & mask_q)));

  // R4
  vector_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1:1] == '0 && |(status_q & mask_q)) |->
      (bus_rdata != '0 && bus_rdata[1:0] == 2'b00));

  // R6
  halfword_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_byte && bus_addr[AW-1:1] == (AW-1)'(1)) |=>
      mask_q == $past(bus_wdata[N-1:0]));

  // R9
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[AW-1:1] != (AW-1)'(1)) |=> $stable(mask_q));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1:1] > (AW-1)'(1)) |-> bus_rdata == '0);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(NUM_LINES), .AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_byte  (bus_byte),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .status_q  (status_q),
  .mask_q    (mask_q)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_byte = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_vec(input logic [15:0] p);
    for (int k = 0; k < 16; k++)
      if (p[k]) return 16'((k + 1) * 4);
    return 16'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic write_reg(input logic [3:0] a, input logic byte_w, input logic [15:0] d);
    bus_addr = a; bus_byte = byte_w; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [15:0] rq, input logic [15:0] m);
    logic [15:0] d;
    read_reg(4'h0, d);
    check(req, d, exp_vec(rq & m));
    check(req, {15'h0, irq_out}, {15'h0, |(rq & m)});
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] lfsr;
    logic [15:0] m;
    logic [15:0] rq;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    read_reg(4'h2, d); check("R1 mask", d, 16'h0010);
    read_reg(4'h0, d); check("R1 vector", d, 16'h0000);
    check("R1 irq_out", {15'h0, irq_out}, 16'h0);

    // R3 default-enabled line 4
    irq_req = 16'h0010; tick();
    expect_state("R3 line4 default", 16'h0010, 16'h0010);
    irq_req = 16'h0020; tick();
    expect_state("R5 line5 masked", 16'h0020, 16'h0010);

    // R6 full enable, R2/R4 single-line sweep
    write_reg(4'h2, 1'b0, 16'hFFFF);
    read_reg(4'h2, d); check("R6 mask readback", d, 16'hFFFF);
    read_reg(4'h3, d); check("R6 mask odd offset", d, 16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      irq_req = 16'(1 << i); tick();
      expect_state("R4 single line", irq_req, 16'hFFFF);
      irq_req = 16'h0; tick();
      expect_state("R2 line released", 16'h0, 16'hFFFF);
    end
    // R4 lowest wins among upper bits
    for (int i = 0; i < 16; i++) begin
      irq_req = 16'hFFFF << i; tick();
      expect_state("R4 lowest priority", irq_req, 16'hFFFF);
    end

    // R5 single-bit masks
    for (int i = 0; i < 16; i++) begin
      m = 16'(1 << i);
      write_reg(4'h2, 1'b0, m);
      irq_req = 16'hFFFF; tick();
      expect_state("R5 only enabled line", 16'hFFFF, m);
      irq_req = ~m; tick();
      expect_state("R5 all others masked", ~m, m);
    end

    // R3/R4/R5 pseudo-random pairs
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq = lfsr & {lfsr[7:0], lfsr[15:8]};
      write_reg(4'h2, 1'b0, m);
      irq_req = rq; tick();
      expect_state("R3 random pattern", rq, m);
    end

    // R7 byte merges
    irq_req = 16'h0;
    write_reg(4'h2, 1'b0, 16'h1234);
    write_reg(4'h3, 1'b1, 16'h00AB);
    read_reg(4'h2, d); check("R7 upper byte", d, 16'hAB34);
    write_reg(4'h2, 1'b1, 16'hFFCD);
    read_reg(4'h2, d); check("R7 lower byte", d, 16'hABCD);

    // R9 foreign writes
    write_reg(4'h0, 1'b0, 16'h5555);
    write_reg(4'h1, 1'b1, 16'h00EE);
    write_reg(4'h6, 1'b0, 16'h0F0F);
    write_reg(4'hE, 1'b1, 16'h0077);
    read_reg(4'h2, d); check("R9 mask unchanged", d, 16'hABCD);

    // R10 empty offsets
    for (int a = 4; a < 16; a++) begin
      read_reg(4'(a), d); check("R10 empty read", d, 16'h0);
    end

    // R8 mask write and request change in one cycle
    write_reg(4'h2, 1'b0, 16'h0000);
    irq_req = 16'h0; tick();
    irq_req = 16'h0080;
    write_reg(4'h2, 1'b0, 16'h0080);
    expect_state("R8 enable with request", 16'h0080, 16'h0080);
    irq_req = 16'h0084;
    write_reg(4'h2, 1'b0, 16'h0000);
    expect_state("R8 disable with request", 16'h0084, 16'h0000);
    irq_req = 16'h0004;
    write_reg(4'h2, 1'b1, 16'h0004);
    expect_state("R8 byte enable with request", 16'h0004, 16'h0004);

    // R2 all lines drop
    irq_req = 16'h0; tick();
    expect_state("R2 all low", 16'h0, 16'h0004);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule